// File: doc/BRIEF.md
# Trimmed Seconds Divider

This block turns a 32.768 kHz oscillator, presented as a one-cycle clock-enable on the system clock, into a one-second tick for a calendar counter further down the line. It keeps a second count within the minute and a minute index within a repeating 64-minute trim cycle. Digital trim changes the length of one second per minute. Positive trim shortens that second and negative trim lengthens it, so a crystal that runs slightly fast or slow can be corrected without any analogue tuning.

The trim value is a 6-bit field. Bits 4..0 hold a magnitude N from 0 to 31, and bit 5 holds the direction. With magnitude N, the first second of each of the first 2×N minutes of the 64-minute cycle is adjusted. A stop input freezes the divider so a backup supply lasts longer. A test-mode input brings out a nominal 512 Hz square wave. This wave comes from its own counter, so it can be compared against a reference while the trim is set to any value.

Top module: `rtc_cal_divider`

## Requirements
- R1: With trim magnitude 0, each second lasts exactly TICKS_PER_SEC (32768) counted oscillator enables. `sec_tick` is a one-cycle pulse in the cycle after the clock edge that counts the final enable of the second.
- R2: A minute consists of SECS_PER_MIN (60) seconds. `minute_idx` advances by one on the tick that ends the last second of a minute, runs from 0 to 63 and then wraps to 0, and does not change at any other time.
- R3: With magnitude N, only second 0 of minutes 0 to 2N−1 is adjusted. All other seconds keep the nominal length.
- R4: When `cal_trim[5]` is 1 (speed up), an adjusted second is FAST_TRIM (256) enables shorter than nominal.
- R5: When `cal_trim[5]` is 0 (slow down) and N > 0, an adjusted second is SLOW_TRIM (128) enables longer than nominal.
- R6: Over one full 64-minute cycle, the total length differs from nominal by −2×N×FAST_TRIM enables for positive trim and by +2×N×SLOW_TRIM enables for negative trim. At the default sizes these are −512·N and +256·N.
- R7: `cal_trim` is sampled only at the tick that ends a minute. A change made part-way through a minute does not alter any second of that minute.
- R8: While `osc_stop` is 1, enables are ignored. No tick is produced, and the divider keeps its count, so the second in progress is stretched by exactly the number of stopped cycles.
- R9: While `cal_test_en` is 1, `test_wave` toggles every TEST_HALF (32) counted enables, whatever the trim value. The first toggle comes TEST_HALF enables after the mode is entered. The cycle after the mode is cleared, `test_wave` is 0.
- R10: During reset, `sec_tick`, `minute_idx` and `test_wave` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| osc_stop | input | 1 | 1 halts the oscillator count |
| cal_trim | input | 6 | [4:0] trim magnitude, [5] direction (1 = speed up) |
| cal_test_en | input | 1 | Enables the 512 Hz test wave |
| sec_tick | output | 1 | One-cycle pulse per second |
| minute_idx | output | MIN_W (6) | Minute position in the trim cycle |
| test_wave | output | 1 | Nominal 512 Hz square wave in test mode |

## Verification
The hardest case to reach is a trim change that lands in the middle of a minute. It has to be shown that the old value still governs the remaining seconds and that the new value takes over exactly at the wrap. The bench runs with smaller second and minute sizes so that several complete 64-minute cycles fit in the run. It changes the trim right after the tick that ends second 0, and it measures the length of every following second against its own model of which value is latched. Totals over a whole cycle at magnitudes 5 and 31 confirm that the adjustment is applied to the right number of minutes.

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider #(
  parameter int TICKS_PER_SEC  = 32768,
  parameter int FAST_TRIM      = 256,
  parameter int SLOW_TRIM      = 128,
  parameter int SECS_PER_MIN   = 60,
  parameter int MINS_PER_CYCLE = 64,
  parameter int TEST_HALF      = 32,
  localparam int MIN_W         = $clog2(MINS_PER_CYCLE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             osc_stop,
  input  logic [5:0]       cal_trim,
  input  logic             cal_test_en,
  output logic             sec_tick,
  output logic [MIN_W-1:0] minute_idx,
  output logic             test_wave
);

  localparam int DIV_W = $clog2(TICKS_PER_SEC + SLOW_TRIM);
  localparam int SEC_W = $clog2(SECS_PER_MIN);
  localparam int TW    = $clog2(TEST_HALF + 1);
  localparam logic [DIV_W-1:0] LIM_NOM  = DIV_W'(TICKS_PER_SEC - 1);
  localparam logic [DIV_W-1:0] LIM_FAST = DIV_W'(TICKS_PER_SEC - 1 - FAST_TRIM);
  localparam logic [DIV_W-1:0] LIM_SLOW = DIV_W'(TICKS_PER_SEC - 1 + SLOW_TRIM);

  logic [DIV_W-1:0] div_cnt, limit;
  logic [SEC_W-1:0] sec_cnt;
  logic [4:0]       mag_q;
  logic             dir_q;
  logic [TW-1:0]    tst_cnt;
  logic             adv, adj, sec_end, min_end;

  assign adv     = osc_tick & ~osc_stop;
  assign adj     = (sec_cnt == '0) && (int'(minute_idx) < 2 * int'(mag_q));
  assign limit   = !adj ? LIM_NOM : (dir_q ? LIM_FAST : LIM_SLOW);
  assign sec_end = adv && (div_cnt == limit);
  assign min_end = sec_end && (sec_cnt == SEC_W'(SECS_PER_MIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt    <= '0;
      sec_cnt    <= '0;
      minute_idx <= '0;
      mag_q      <= '0;
      dir_q      <= 1'b0;
      sec_tick   <= 1'b0;
    end else begin
      sec_tick <= sec_end;
      if (adv) div_cnt <= sec_end ? '0 : div_cnt + 1'b1;
      if (sec_end) sec_cnt <= min_end ? '0 : sec_cnt + 1'b1;
      if (min_end) begin
        minute_idx <= (minute_idx == MIN_W'(MINS_PER_CYCLE - 1)) ? '0 : minute_idx + 1'b1;
        mag_q      <= cal_trim[4:0];
        dir_q      <= cal_trim[5];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cal_test_en) begin
      tst_cnt   <= '0;
      test_wave <= 1'b0;
    end else if (adv) begin
      if (tst_cnt == TW'(TEST_HALF - 1)) begin
        tst_cnt   <= '0;
        test_wave <= ~test_wave;
      end else begin
        tst_cnt <= tst_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_cal_divider_chk.sv
module rtc_cal_divider_chk #(
  parameter int MIN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_tick,
  input logic             osc_stop,
  input logic             cal_test_en,
  input logic             sec_tick,
  input logic [MIN_W-1:0] minute_idx,
  input logic             test_wave
);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  a_r8_stop_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop || !osc_tick) |=> !sec_tick);

  a_r2_minute_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(minute_idx) |-> sec_tick);

  a_r2_minute_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(minute_idx) |-> (minute_idx == MIN_W'($past(minute_idx) + 1'b1) || minute_idx == '0));

  a_r9_test_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_test_en |=> !test_wave);

  a_r9_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_test_en && (osc_stop || !osc_tick)) |=> $stable(test_wave));

endmodule

bind rtc_cal_divider rtc_cal_divider_chk #(.MIN_W(MIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_stop(osc_stop),
  .cal_test_en(cal_test_en), .sec_tick(sec_tick), .minute_idx(minute_idx),
  .test_wave(test_wave)
);

// File: tb/rtc_cal_divider_test.sv
module rtc_cal_divider_test;
  localparam int NOM = 64, FAST = 16, SLOW = 8, SECS = 4, CYC = 64, HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, osc_stop = 1'b0, cal_test_en = 1'b0;
  logic [5:0] cal_trim = '0;
  logic sec_tick, test_wave;
  logic [5:0] minute_idx;

  int cyc = 0, ncyc = 0, osc_div = 1, last_t = 0;
  int s_m = 0, m_m = 0, mq_m = 0, sq_m = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    osc_tick <= ((ncyc % osc_div) == osc_div - 1);
    ncyc <= ncyc + 1;
  end

  rtc_cal_divider #(.TICKS_PER_SEC(NOM), .FAST_TRIM(FAST), .SLOW_TRIM(SLOW),
    .SECS_PER_MIN(SECS), .MINS_PER_CYCLE(CYC), .TEST_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_stop(osc_stop),
    .cal_trim(cal_trim), .cal_test_en(cal_test_en), .sec_tick(sec_tick),
    .minute_idx(minute_idx), .test_wave(test_wave));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len();
    if (s_m == 0 && m_m < 2 * mq_m) return sq_m != 0 ? NOM - FAST : NOM + SLOW;
    return NOM;
  endfunction

  task automatic model_adv();
    s_m++;
    if (s_m == SECS) begin
      s_m = 0;
      m_m = (m_m + 1) % CYC;
      mq_m = int'(cal_trim[4:0]);
      sq_m = int'(cal_trim[5]);
    end
  endtask

  task automatic next_tick(output int len);
    forever begin
      @(negedge clk);
      if (sec_tick) break;
    end
    len = cyc - last_t;
    last_t = cyc;
  endtask

  task automatic run_secs(input int n, input string tag, input bit skip, output int total);
    int len, e;
    total = 0;
    for (int i = 0; i < n; i++) begin
      next_tick(len);
      e = exp_len() * osc_div;
      if (!(skip && i == 0)) check(len == e, tag, len, e);
      total += len;
      model_adv();
      check(int'(minute_idx) == m_m, "R2 minute index", int'(minute_idx), m_m);
    end
  endtask

  task automatic to_boundary(input string tag);
    int t;
    while (s_m != 0) run_secs(1, tag, 0, t);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(sec_tick == 0, "R10 sec_tick in reset", sec_tick, 0);
    check(minute_idx == 0, "R10 minute_idx in reset", minute_idx, 0);
    check(test_wave == 0, "R10 test_wave in reset", test_wave, 0);
    rst_n = 1'b1;
    last_t = cyc;
  endtask

  task automatic t_nominal();
    int t;
    run_secs(10, "R1 nominal second", 0, t);
    check(t == 10 * NOM, "R1 nominal total", t, 10 * NOM);
  endtask

  task automatic t_full_cycle(input logic [5:0] trim, input string tag);
    int t, e;
    cal_trim = trim;
    to_boundary(tag);
    to_boundary(tag);
    if (mq_m != int'(trim[4:0])) run_secs(SECS, tag, 0, t);
    run_secs(SECS * CYC, tag, 0, t);
    e = SECS * CYC * NOM + (trim[5] ? -2 * int'(trim[4:0]) * FAST : 2 * int'(trim[4:0]) * SLOW);
    check(t == e, "R6 cycle total", t, e);
  endtask

  task automatic t_midchange();
    int t;
    to_boundary("R7 align");
    run_secs(1, "R7 second 0", 0, t);
    cal_trim = 6'b1_11111;
    run_secs(SECS - 1, "R7 rest of minute", 0, t);
    check(t == (SECS - 1) * NOM, "R7 no effect mid-minute", t, (SECS - 1) * NOM);
    run_secs(SECS, "R7 next minute", 0, t);
    cal_trim = 6'b0;
  endtask

  task automatic t_slow_osc();
    int t;
    osc_div = 3;
    run_secs(5, "R1 sparse enables", 1, t);
    osc_div = 1;
    run_secs(3, "R1 dense enables", 1, t);
  endtask

  task automatic t_stop();
    int t, len, e, seen;
    logic [5:0] m0;
    run_secs(1, "R8 sync", 0, t);
    repeat (10) @(negedge clk);
    osc_stop = 1'b1;
    m0 = minute_idx;
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (sec_tick) seen++;
    end
    check(seen == 0, "R8 no tick while stopped", seen, 0);
    check(minute_idx == m0, "R8 minute frozen", minute_idx, m0);
    osc_stop = 1'b0;
    next_tick(len);
    e = exp_len() + 100;
    check(len == e, "R8 stretched second", len, e);
    model_adv();
  endtask

  task automatic t_test_wave(input logic [5:0] trim);
    logic prev;
    int t0;
    cal_trim = trim;
    @(negedge clk);
    cal_test_en = 1'b1;
    prev = 1'b0;
    t0 = cyc;
    for (int k = 0; k < 4; k++) begin
      while (test_wave == prev) @(negedge clk);
      check(cyc - t0 == HALF, "R9 half period", cyc - t0, HALF);
      prev = test_wave;
      t0 = cyc;
    end
    cal_test_en = 1'b0;
    @(negedge clk);
    check(test_wave == 0, "R9 off forces low", test_wave, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nominal();
    t_full_cycle(6'b1_00101, "R4 R3 fast trim");
    t_full_cycle(6'b0_11111, "R5 R3 slow trim");
    t_midchange();
    t_slow_osc();
    t_stop();
    t_test_wave(6'b1_11111);
    t_test_wave(6'b0_01010);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule